// File: doc/BRIEF.md
# Single-Clock FIFO with Same-Cycle Read Bypass

This block is a first-in first-out queue that runs on one clock. Words go in through a write enable and a data bus and come out through a read enable and a data bus. The data width is a parameter. The depth is a power-of-two parameter. A word counter that is one bit wider than the address pointers tracks how full the queue is. From that counter the block drives registered empty, full, almost-full and almost-empty indications.

When the queue is empty and a read and a write arrive in the same cycle, both addresses point at the same entry. The incoming word is then handed straight to the read side, and the queue stays empty. A parameter chooses how read data is presented:
- In combinational mode, the word at the head appears on the read bus in the same cycle as the read.
- In registered mode, the word is captured on the accepted read and appears in the cycle after it.

The almost flags can be switched off with a parameter, and their thresholds can be set.

Top module: `sfifo_bypass`

## Requirements
- R1: While `rst` is high, a clock edge sets `empty` to 1 and `full` to 0. It also sets `almost_full` to 0, and sets `almost_empty` to 1 when the almost flags are enabled. Read data is not reset.
- R2: Words leave the queue in exactly the order in which they were accepted.
- R3: A write presented while `full` is 1 is dropped. The stored contents and the fill level are unchanged.
- R4: A read presented while `empty` is 1, with no write in the same cycle, is dropped. The fill level stays 0.
- R5: When `empty` is 1 and `rd_en` and `wr_en` are both 1, the read returns `wr_data` (in the same cycle in combinational mode). The queue stays empty afterwards.
- R6: A read and a write that are both accepted in one cycle leave the fill level, and therefore every flag, unchanged.
- R7: `empty` is 1 exactly when the fill level after the previous edge is 0, and `full` is 1 exactly when it equals DEPTH. Both come from flip-flops.
- R8: With the almost flags enabled, `almost_full` is 1 exactly when the fill level is at least the almost-full threshold (default DEPTH-2). It is registered.
- R9: With the almost flags enabled, `almost_empty` is 1 exactly when the fill level is at most the almost-empty threshold (default 2). It is registered.
- R10: With `REG_OUT`=1, `rd_data` shows the word of an accepted read one cycle after that read, and holds it until the next accepted read.
- R11: With the almost flags disabled, `almost_full` and `almost_empty` stay 0 at all times.
- R12: Both pointers wrap from entry DEPTH-1 to entry 0, so ordering holds across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | Queue holds DEPTH words (registered) |
| almost_full | output | 1 | Fill level at or above the almost-full threshold (registered) |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Word read from the head |
| empty | output | 1 | Queue holds no words (registered) |
| almost_empty | output | 1 | Fill level at or below the almost-empty threshold (registered) |

## Verification
A read and a write can share a cycle. On an empty queue this takes the bypass path. On a partly filled queue it must leave the level alone. On a full queue only the read may be accepted. Directed steps provoke each of these three cases, and random traffic with shifting write and read biases keeps revisiting them at every fill level. A queue model in the bench decides which requests are accepted, and judges the data returned, the data returned one cycle late by a registered-output instance, and every flag after each edge.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } sfb_op_e;

  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/sfb_mem.sv
module sfb_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ram [DEPTH];

  // write port only, no reset, so the array maps onto RAM resources
  always_ff @(posedge clk) begin
    if (we) begin
      ram[waddr] <= wdata;
    end
  end

  assign rdata = ram[raddr];

endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AW        = $clog2(DEPTH),
  parameter int CW        = AW + 1,
  parameter bit EN_ALMOST = 1'b1,
  parameter int AF_TH     = DEPTH - 2,
  parameter int AE_TH     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_acc,
  output logic          bypass,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty
);

  logic          rd_acc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  sfb_op_e       op;

  always_comb begin
    wr_acc = wr_en & ~full;
    // equal pointers without full means an empty queue
    bypass = rd_en & wr_acc & (rd_ptr == wr_ptr);
    rd_acc = rd_en & (~empty | bypass);
  end

  always_comb begin
    if (wr_acc && !rd_acc) begin
      op = OP_PUSH;
    end else if (rd_acc && !wr_acc) begin
      op = OP_POP;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    case (op)
      OP_PUSH: cnt_nxt = cnt + CW'(1);
      OP_POP:  cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
    end else begin
      if (wr_acc) begin
        wr_ptr <= wr_ptr + AW'(1);
      end
      if (rd_acc) begin
        rd_ptr <= rd_ptr + AW'(1);
      end
      cnt   <= cnt_nxt;
      empty <= (cnt_nxt == '0);
      full  <= (cnt_nxt == CW'(DEPTH));
    end
  end

  generate
    if (EN_ALMOST) begin : g_almost
      always_ff @(posedge clk) begin
        if (rst) begin
          almost_full  <= 1'b0;
          almost_empty <= 1'b1;
        end else begin
          almost_full  <= (cnt_nxt >= CW'(AF_TH));
          almost_empty <= (cnt_nxt <= CW'(AE_TH));
        end
      end
    end else begin : g_no_almost
      always_ff @(posedge clk) begin
        almost_full  <= 1'b0;
        almost_empty <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/sfifo_bypass.sv
module sfifo_bypass
  import sfb_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter bit REG_OUT   = 1'b0,
  parameter bit EN_ALMOST = 1'b1,
  parameter int AF_TH     = DEPTH - 2,
  parameter int AE_TH     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  generate
    if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("sfifo_bypass: DEPTH must be a power of two, at least 2");
    end
  endgenerate

  logic          wr_acc;
  logic          bypass;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] head_word;

  sfb_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .CW(CW), .EN_ALMOST(EN_ALMOST),
    .AF_TH(AF_TH), .AE_TH(AE_TH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .wr_acc(wr_acc), .bypass(bypass), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty),
    .almost_full(almost_full), .almost_empty(almost_empty)
  );

  sfb_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_acc), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(mem_q)
  );

  assign head_word = bypass ? wr_data : mem_q;

  generate
    if (REG_OUT) begin : g_reg_out
      logic          cap_en;
      logic [DW-1:0] rd_q;
      assign cap_en = rd_en & (~empty | bypass);
      always_ff @(posedge clk) begin
        if (cap_en) begin
          rd_q <= head_word;
        end
      end
      assign rd_data = rd_q;
    end else begin : g_comb_out
      assign rd_data = head_word;
    end
  endgenerate

endmodule

// File: rtl/sfifo_bypass_chk.sv
module sfifo_bypass_chk #(
  parameter int DW        = 8,
  parameter bit REG_OUT   = 1'b0,
  parameter bit EN_ALMOST = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          full,
  input logic          almost_full,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          almost_empty
);

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (empty && !full));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> full);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> empty);

  p_bypass_stays_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && wr_en) |=> empty);

  p_level_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && wr_en && rd_en) |=> ($stable(empty) && $stable(full)));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  generate
    if (REG_OUT) begin : g_reg
      p_bypass_data_r10: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && wr_en) |=> (rd_data == $past(wr_data)));
    end else begin : g_comb
      p_bypass_data_r5: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && wr_en) |-> (rd_data == wr_data));
    end
    if (EN_ALMOST) begin : g_al
      p_full_implies_af_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> almost_full);
      p_empty_implies_ae_r9: assert property (@(posedge clk) disable iff (rst)
        empty |-> almost_empty);
    end else begin : g_noal
      p_almost_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!almost_full && !almost_empty));
    end
  endgenerate

endmodule

bind sfifo_bypass sfifo_bypass_chk #(
  .DW(DW), .REG_OUT(REG_OUT), .EN_ALMOST(EN_ALMOST)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
  .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
  .empty(empty), .almost_empty(almost_empty)
);

// File: tb/sfifo_bypass_tb.sv
module sfifo_bypass_tb;

  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic          full0, af0, empty0, ae0;
  logic          full1, af1, empty1, ae1;
  logic          full2, af2, empty2, ae2;
  logic [DW-1:0] rd0, rd1, rd2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] reg_exp;
  bit            reg_valid = 1'b0;
  string         ctx = "R7";
  string         rdtag = "R2";

  always #5 clk = ~clk;

  sfifo_bypass #(.DW(DW), .DEPTH(DEPTH), .REG_OUT(1'b0), .EN_ALMOST(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full0),
    .almost_full(af0), .rd_en(rd_en), .rd_data(rd0), .empty(empty0),
    .almost_empty(ae0));

  sfifo_bypass #(.DW(DW), .DEPTH(DEPTH), .REG_OUT(1'b1), .EN_ALMOST(1'b1)) u_dut_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full1),
    .almost_full(af1), .rd_en(rd_en), .rd_data(rd1), .empty(empty1),
    .almost_empty(ae1));

  sfifo_bypass #(.DW(DW), .DEPTH(DEPTH), .REG_OUT(1'b0), .EN_ALMOST(1'b0)) u_dut_noal (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full2),
    .almost_full(af2), .rd_en(rd_en), .rd_data(rd2), .empty(empty2),
    .almost_empty(ae2));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_af(input int n);
    return n >= DEPTH - 2;
  endfunction

  function automatic bit exp_ae(input int n);
    return n <= 2;
  endfunction

  // one clock: drive, check at the falling edge, update the model
  task automatic step(input logic we, input logic [DW-1:0] wd, input logic re);
    logic          wacc;
    logic          racc;
    logic [DW-1:0] rv;
    int            n;
    wr_en   = we;
    wr_data = wd;
    rd_en   = re;
    @(negedge clk);
    n = q.size();
    chk({ctx, " R7 empty"}, empty0, n == 0);
    chk({ctx, " R7 full"}, full0, n == DEPTH);
    chk("R8 almost_full", af0, exp_af(n));
    chk("R9 almost_empty", ae0, exp_ae(n));
    chk("R10 reg-instance empty", empty1, n == 0);
    chk("R11 almost_full off", af2, 1'b0);
    chk("R11 almost_empty off", ae2, 1'b0);
    chk("R11 no-almost instance full", full2, n == DEPTH);
    wacc = we && (n != DEPTH);
    racc = re && ((n != 0) || wacc);
    rv   = '0;
    if (racc) begin
      rv = (n == 0) ? wd : q[0];
      chk((n == 0) ? "R5 bypass data" : rdtag, rd0, rv);
    end
    if (reg_valid) chk("R10 registered data", rd1, reg_exp);
    if (racc) begin
      reg_exp   = rv;
      reg_valid = 1'b1;
    end
    if (wacc) q.push_back(wd);
    if (racc) void'(q.pop_front());
    @(posedge clk);
    #1;
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: state after reset edges
    chk("R1 empty", empty0, 1'b1);
    chk("R1 full", full0, 1'b0);
    chk("R1 almost_full", af0, 1'b0);
    chk("R1 almost_empty", ae0, 1'b1);
    chk("R1 no-almost almost_empty", ae2, 1'b0);
    @(posedge clk);
    #1;
    rst = 1'b0;

    // R4: read on empty with no write is dropped
    step(1'b0, 8'h00, 1'b1);
    ctx = "R4";
    step(1'b0, 8'h00, 1'b0);
    ctx = "R7";

    // R5: bypass on empty, queue stays empty
    step(1'b1, 8'hA5, 1'b1);
    ctx = "R5";
    step(1'b0, 8'h00, 1'b0);
    ctx = "R7";

    // fill to full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h10 + i), 1'b0);
    // R3: writes while full are dropped
    ctx = "R3";
    step(1'b1, 8'hEE, 1'b0);
    step(1'b1, 8'hEF, 1'b0);
    // read and write together while full: only the read is taken
    step(1'b1, 8'hED, 1'b1);
    step(1'b1, 8'h77, 1'b0);
    ctx = "R7";
    rdtag = "R3 order after dropped writes";
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 1'b1);

    // R6: simultaneous accepted read and write keeps the level
    ctx = "R6";
    rdtag = "R6 data";
    for (int i = 0; i < 12; i++) step(1'b1, 8'(8'h40 + i), 1'b1);
    ctx = "R7";

    // R12: drain across the wrap point
    rdtag = "R12 order across wrap";
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 8'h00, 1'b1);

    // random traffic with shifting biases
    rdtag = "R2 order";
    for (int blk = 0; blk < 40; blk++) begin
      int wb;
      int rb;
      wb = 20 + int'($urandom % 70);
      rb = 20 + int'($urandom % 70);
      for (int i = 0; i < 80; i++) begin
        step(($urandom % 100) < wb, 8'($urandom), ($urandom % 100) < rb);
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 8'h00, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule